// File: doc/BRIEF.md
# Serial Codec Register File Responder

This block sits on the codec side of a framed serial link. It stores sixteen 16-bit registers and serves one register access per frame. A rising edge on the frame-sync input starts a subframe. The subframe then carries 64 bits, one bit per clock, most significant bit first. In the inbound stream, bits 46:43 select a register, bit 42 chooses between a write (1) and a read (0), and bits 15:0 carry the write data.

The outbound stream has the same layout. The responder echoes the register address, returns 0 in the read/write position, and places the selected register's contents in the data field. It does this on every frame, whether the access is a read or a write. The register is read as soon as the read/write bit has arrived. A write is only stored in the cycle after the last subframe bit, which is the 65th bit time of the frame. A frame that carries a write therefore reports the old value, and the new value is seen from the next frame onward.

Top module: `codec_regfile_resp`

## Requirements
- R1: All sixteen registers are 16 bits wide and hold zero after reset. A read frame issued after reset returns zero in the data field for every address.
- R2: A cycle in which `fsync` is high after being low starts a frame. `sdi` and `sdo` carry frame bit 63 in the next clock, and the following bits in descending order, one per clock. In the sync cycle itself, `sdo` is 0.
- R3: Inbound field positions: bits 46:43 form the register address (bit 46 is its MSB), bit 42 is the write flag (1 = write), and bits 15:0 are the write data (bit 15 is the MSB). All other inbound bits are ignored.
- R4: Outbound bits 46:43 echo the address received in the same frame, and outbound bit 42 is always 0.
- R5: Outbound bits 15:0 hold the addressed register's contents as they stood when bit 42 arrived. In a frame that carries a write, this is the value from before the write.
- R6: A write is stored in the clock after frame bit 0 (the 65th bit time). The next frame that reads that address returns the written value.
- R7: A frame whose flag is 0 leaves the addressed register unchanged, whatever its data field holds.
- R8: A new sync edge that arrives before the 65th bit time restarts the count from bit 63, and the interrupted frame stores nothing.
- R9: A sync edge may fall in the 65th bit time of the previous frame. The pending write is still stored, and the new frame proceeds normally.
- R10: `sdo` is 0 on all bits outside the address, flag and data fields, and at all times outside a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; one frame bit per rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| fsync | input | 1 | Frame sync; its rising edge starts a subframe |
| sdi | input | 1 | Serial data from the host, MSB first |
| sdo | output | 1 | Serial data to the host, MSB first |

## Verification
The hardest case to reach is a sync edge that lands exactly on the 65th bit time of a frame carrying a write. In that cycle the commit and the restart of the bit count must both happen. The bench brings this about by raising sync on that very cycle and then reading the same register in the new frame. The second difficult case is a frame that is cut short after its write flag has been latched. The bench truncates write frames at bit 33 and bit 23 and then reads the target register back. This shows that nothing was stored and that the data field of the next frame is timed correctly.

// File: rtl/codec_regfile_resp.sv
module codec_regfile_resp #(
  parameter int AW       = 4,
  parameter int DW       = 16,
  parameter int SUB_BITS = 64,
  parameter int ADDR_MSB = 46,
  parameter int FLAG_BIT = 42
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fsync,
  input  logic sdi,
  output logic sdo
);
  localparam int NREG = 1 << AW;
  localparam int CW   = $clog2(SUB_BITS + 2);
  localparam logic [CW-1:0] P_ADDR0  = CW'(SUB_BITS - 1 - ADDR_MSB);
  localparam logic [CW-1:0] P_FLAG   = CW'(SUB_BITS - 1 - FLAG_BIT);
  localparam logic [CW-1:0] P_DATA0  = CW'(SUB_BITS - DW);
  localparam logic [CW-1:0] P_COMMIT = CW'(SUB_BITS);
  localparam logic [CW-1:0] P_IDLE   = CW'(SUB_BITS + 1);

  logic          sync_q;
  logic [CW-1:0] pos;
  logic [AW-1:0] addr;
  logic          wr;
  logic [DW-1:0] wdata, txsh;
  logic [DW-1:0] regs [NREG];

  wire rise    = fsync & ~sync_q;
  wire in_addr = (pos >= P_ADDR0) && (pos < P_FLAG);
  wire in_flag = (pos == P_FLAG);
  wire in_data = (pos >= P_DATA0) && (pos < P_COMMIT);
  wire commit  = (pos == P_COMMIT) && wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
      pos    <= P_IDLE;
      addr   <= '0;
      wr     <= 1'b0;
      wdata  <= '0;
      txsh   <= '0;
    end else begin
      sync_q <= fsync;
      if (rise)               pos <= '0;
      else if (pos != P_IDLE) pos <= pos + 1'b1;
      if (in_addr) addr <= {addr[AW-2:0], sdi};
      if (in_flag) begin
        wr   <= sdi;
        txsh <= regs[addr];
      end else if (in_data) begin
        txsh <= {txsh[DW-2:0], 1'b0};
      end
      if (in_data) wdata <= {wdata[DW-2:0], sdi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (commit) begin
      regs[addr] <= wdata;
    end
  end

  assign sdo = in_addr ? sdi : (in_data ? txsh[DW-1] : 1'b0);

  AST_SYNC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> (pos == '0)); // R2
  AST_FLAG_ECHO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    in_flag |-> !sdo); // R4
  AST_READBACK_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (pos == P_DATA0) |-> (txsh == regs[addr])); // R5
  AST_HOLD_OUTSIDE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_addr && !commit) |=> $stable(regs[addr])); // R7
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (pos >= P_COMMIT) |-> !sdo); // R10
endmodule

// File: tb/tb_codec_regfile_resp.sv
module tb_codec_regfile_resp;
  logic clk = 1'b0, rst_n = 1'b0, fsync = 1'b0, sdi = 1'b0;
  wire  sdo;
  int checks = 0, errors = 0, cyc = 0;
  logic [15:0] mem [16];
  bit sync_pending = 0;

  codec_regfile_resp dut (.clk(clk), .rst_n(rst_n), .fsync(fsync), .sdi(sdi), .sdo(sdo));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input logic act, input logic exp, input string req, input int bitno);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s bit %0d: sdo=%b expected %b", req, bitno, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); fsync = 1'b0; sdi = 1'b0; #1;
      chk(sdo, 1'b0, "R10", -1);
    end
  endtask

  task automatic frame(input logic [3:0] a, input logic w, input logic [15:0] d,
                       input int nbits, input bit b2b, input string req);
    logic [15:0] old;
    logic b, e;
    if (!sync_pending) begin
      @(negedge clk); fsync = 1'b1; sdi = 1'b0; #1;
      chk(sdo, 1'b0, "R2", 64);
    end
    sync_pending = 0;
    old = mem[a];
    for (int k = 0; k < nbits; k++) begin
      int bn = 63 - k;
      string r;
      if (bn <= 46 && bn >= 43) begin b = a[bn-43]; e = a[bn-43]; r = "R4"; end
      else if (bn == 42)        begin b = w;        e = 1'b0;     r = "R4"; end
      else if (bn <= 15)        begin b = d[bn];    e = old[bn];  r = req;  end
      else                      begin b = 1'b1;     e = 1'b0;     r = "R10"; end
      @(negedge clk); fsync = 1'b0; sdi = b; #1;
      chk(sdo, e, r, bn);
    end
    if (nbits == 64) begin
      @(negedge clk); fsync = b2b; sdi = 1'b0; #1;
      chk(sdo, 1'b0, b2b ? "R9" : "R6", -1);
      if (w) mem[a] = d;
      sync_pending = b2b;
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    #1 chk(sdo, 1'b0, "R1", -1);
    rst_n = 1'b1;
    idle(3);
    for (int i = 0; i < 16; i++) frame(4'(i), 1'b0, 16'hFFFF, 64, 0, "R1");
    idle(2);
    frame(4'd5, 1'b1, 16'hA5C3, 64, 0, "R5");
    frame(4'd5, 1'b0, 16'h0000, 64, 0, "R6");
    frame(4'd5, 1'b1, 16'h1234, 64, 1, "R5");
    frame(4'd5, 1'b0, 16'h0000, 64, 1, "R9");
    frame(4'd5, 1'b0, 16'hFFFF, 64, 0, "R7");
    frame(4'd5, 1'b0, 16'h0000, 64, 0, "R7");
    frame(4'd9, 1'b1, 16'hBEEF, 30, 0, "R8");
    frame(4'd9, 1'b0, 16'h0000, 64, 0, "R8");
    frame(4'd9, 1'b1, 16'hBEEF, 40, 0, "R8");
    frame(4'd9, 1'b0, 16'h0000, 64, 0, "R8");
    for (int i = 0; i < 16; i++)
      frame(4'(i), 1'b1, 16'(i * 16'h1111) ^ 16'h0F0F, 64, (i % 2) == 1, "R3");
    for (int i = 15; i >= 0; i--) frame(4'(i), 1'b0, 16'h5555, 64, 0, "R3");
    frame(4'd0, 1'b1, 16'h8001, 64, 1, "R6");
    frame(4'd15, 1'b1, 16'h7FFE, 64, 1, "R6");
    frame(4'd0, 1'b0, 16'h0000, 64, 1, "R6");
    frame(4'd15, 1'b0, 16'h0000, 64, 0, "R6");
    idle(4);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule